// File: doc/BRIEF.md
# SCSI Bus Parity and Direction Unit

This block connects a byte-wide internal data path to an 8-bit single-ended SCSI data bus with one parity line. Every bus line is active-low and open-collector. The block never drives a line high. It either pulls a line low or releases it so that the terminators raise it. In output mode it turns a logical byte into pin-level enables for the data lines and adds an odd-parity bit. In input mode it inverts the sampled pin levels back into a logical byte and checks the byte's parity.

A controller chooses the direction through a single mode input. Every direction change passes through a turnaround interval in which the block drives no line, so the two sides of the bus never drive at the same time. Received bytes are captured only on a strobe. A parity mismatch sets a sticky error flag. The flag stays set for the rest of the transfer, so the controller can discard the whole buffer. Parity checking can be switched off by a static configuration input.

Top module: `scsi_par_dir_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, the unit is in input direction (`dir_is_out`=0), drives no line (all `bus_data_oe` and `bus_par_oe` low), and `par_err`=0 and `rx_valid`=0.
- R2: In output direction, `bus_data_oe[i]` is 1 exactly when bit i of the last byte loaded by `tx_load` is 1 (logical 1 = line pulled low). `bus_data_o` and `bus_par_o` are always 0. A load becomes visible on the cycle after the edge that samples it.
- R3: The generated parity is odd. In output direction `bus_par_oe` is 1 exactly when the loaded byte has an even number of ones, so the count of asserted lines among the nine is odd.
- R4: Outside output direction, no data or parity enable is ever high.
- R5: A change of `mode_out` that is sampled at an edge moves the unit into turnaround. After TURN_CYCLES cycles in turnaround (default 1), it takes the direction `mode_out` then requests. So with the default, drive starts two edges after `mode_out` rises and stops one edge after it falls.
- R6: In input direction, an edge with `rx_strobe`=1 stores the bitwise inverse of `bus_data_in` in `rx_byte` and raises `rx_valid` for one cycle after that edge. Strobes in any other direction are ignored: `rx_valid` stays 0 and `par_err` is unchanged.
- R7: A captured byte is a mismatch when the number of low pins among `bus_data_in` and `bus_par_in` is even. With `par_chk_en`=1, a mismatch sets `par_err` after the capturing edge.
- R8: `par_err` stays set over later good bytes until an edge with `err_clr` or `xfer_start`. If a mismatching byte is captured in the same cycle as a clear, the flag ends set.
- R9: With `par_chk_en`=0, captured bytes never set `par_err`, whatever their parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_out | input | 1 | Requested direction, 1 = output |
| par_chk_en | input | 1 | Static parity check enable |
| err_clr | input | 1 | Clears the sticky parity error |
| xfer_start | input | 1 | Marks a new transfer; clears the error |
| tx_byte | input | 8 | Logical byte to send |
| tx_load | input | 1 | Loads `tx_byte` into the drive register |
| bus_data_in | input | 8 | Sampled data pin levels |
| bus_par_in | input | 1 | Sampled parity pin level |
| rx_strobe | input | 1 | Byte-valid strobe for incoming data |
| bus_data_oe | output | 8 | Per-line pull-low enable for the data lines |
| bus_data_o | output | 8 | Driven level for the data lines, always 0 |
| bus_par_oe | output | 1 | Pull-low enable for the parity line |
| bus_par_o | output | 1 | Driven level for the parity line, always 0 |
| rx_byte | output | 8 | Last captured logical byte |
| rx_valid | output | 1 | One-cycle pulse after a capture |
| par_err | output | 1 | Sticky parity error |
| dir_is_out | output | 1 | 1 while the unit is in output direction |

## Verification
Every result of the unit is due one edge after the stimulus that causes it. Captured bytes, `rx_valid` and `par_err` change at the strobe edge. A loaded byte reaches the enables at the load edge. A mode change reaches output direction one edge after turnaround ends. The bench therefore applies each stimulus just after a rising edge and checks one nanosecond after the next rising edge. It also sweeps every byte against both parity levels on receive, and every byte on send.

// File: rtl/scsi_par_pkg.sv
package scsi_par_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        DIR_IN   = 2'd0,
        DIR_TURN = 2'd1,
        DIR_OUT  = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             par;
    } bus_word_t;

    // odd parity bit: makes total count of ones over data and parity odd
    function automatic logic odd_par_bit(input logic [BUS_W-1:0] d);
        return ~(^d);
    endfunction

    // pins are active low: logical word is the inverse of the levels
    function automatic bus_word_t pins_to_logic(input logic [BUS_W-1:0] d,
                                                input logic par);
        bus_word_t w;
        w.data = ~d;
        w.par  = ~par;
        return w;
    endfunction

endpackage

// File: rtl/scsi_dir_ctrl.sv
module scsi_dir_ctrl
    import scsi_par_pkg::*;
#(
    parameter int TURN_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_out,
    output dir_state_e state
);
    localparam int CNT_W = $clog2(TURN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TURN_CYCLES - 1);

    logic [CNT_W-1:0] turn_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DIR_IN;
            turn_cnt <= '0;
        end else begin
            case (state)
                DIR_IN: if (mode_out) begin
                    state    <= DIR_TURN;
                    turn_cnt <= '0;
                end
                DIR_OUT: if (!mode_out) begin
                    state    <= DIR_TURN;
                    turn_cnt <= '0;
                end
                DIR_TURN: begin
                    if (turn_cnt == CNT_LAST) begin
                        state <= mode_out ? DIR_OUT : DIR_IN;
                    end else begin
                        turn_cnt <= turn_cnt + 1'b1;
                    end
                end
                default: state <= DIR_IN;
            endcase
        end
    end

    // R5: no direct jump between driving sides
    assert_no_in_to_out_R5: assert property (@(posedge clk) disable iff (rst)
        (state == DIR_IN) |=> (state != DIR_OUT));
    assert_no_out_to_in_R5: assert property (@(posedge clk) disable iff (rst)
        (state == DIR_OUT) |=> (state != DIR_IN));

endmodule

// File: rtl/scsi_tx_drive.sv
module scsi_tx_drive
    import scsi_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             drive_en,
    input  logic [BUS_W-1:0] tx_byte,
    input  logic             tx_load,
    output logic [BUS_W-1:0] data_oe,
    output logic             par_oe
);
    bus_word_t tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (tx_load) begin
            tx_q.data <= tx_byte;
            tx_q.par  <= odd_par_bit(tx_byte);
        end
    end

    // open collector: enable pulls low only for asserted logical bits
    generate
        for (genvar i = 0; i < BUS_W; i++) begin : g_lane
            assign data_oe[i] = drive_en & tx_q.data[i];
        end
    endgenerate
    assign par_oe = drive_en & tx_q.par;

    // R3: driven word always carries odd number of asserted lines
    assert_odd_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (drive_en && $past(!rst)) |-> ($countones({data_oe, par_oe}) % 2 == 1));
    // R4: released when not driving
    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (data_oe == '0 && !par_oe));

endmodule

// File: rtl/scsi_rx_check.sv
module scsi_rx_check
    import scsi_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             listen_en,
    input  logic             chk_en,
    input  logic             clr,
    input  logic [BUS_W-1:0] pin_data,
    input  logic             pin_par,
    input  logic             strobe,
    output logic [BUS_W-1:0] rx_byte,
    output logic             rx_valid,
    output logic             err
);
    bus_word_t in_w;
    logic      take;
    logic      mismatch;

    assign in_w     = pins_to_logic(pin_data, pin_par);
    assign take     = strobe & listen_en;
    assign mismatch = ~(^{in_w.data, in_w.par});

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            rx_valid <= take;
            if (take) rx_byte <= in_w.data;
            if (take && chk_en && mismatch) err <= 1'b1;
            else if (clr)                   err <= 1'b0;
        end
    end

    // R7/R9: flag rises only on a checked, captured byte
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(err)) |-> ($past(take) && $past(chk_en)));
    // R6: valid only after a capture in input direction
    assert_valid_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rx_valid) |-> $past(strobe && listen_en));
    // R8: flag holds unless cleared
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> err);

endmodule

// File: rtl/scsi_par_dir_unit.sv
module scsi_par_dir_unit
    import scsi_par_pkg::*;
#(
    parameter int TURN_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_out,
    input  logic             par_chk_en,
    input  logic             err_clr,
    input  logic             xfer_start,
    input  logic [BUS_W-1:0] tx_byte,
    input  logic             tx_load,
    input  logic [BUS_W-1:0] bus_data_in,
    input  logic             bus_par_in,
    input  logic             rx_strobe,
    output logic [BUS_W-1:0] bus_data_oe,
    output logic [BUS_W-1:0] bus_data_o,
    output logic             bus_par_oe,
    output logic             bus_par_o,
    output logic [BUS_W-1:0] rx_byte,
    output logic             rx_valid,
    output logic             par_err,
    output logic             dir_is_out
);
    dir_state_e state;

    scsi_dir_ctrl #(.TURN_CYCLES(TURN_CYCLES)) dir_i (
        .clk      (clk),
        .rst      (rst),
        .mode_out (mode_out),
        .state    (state)
    );

    assign dir_is_out = (state == DIR_OUT);

    scsi_tx_drive tx_i (
        .clk      (clk),
        .rst      (rst),
        .drive_en (dir_is_out),
        .tx_byte  (tx_byte),
        .tx_load  (tx_load),
        .data_oe  (bus_data_oe),
        .par_oe   (bus_par_oe)
    );

    assign bus_data_o = '0;
    assign bus_par_o  = 1'b0;

    scsi_rx_check rx_i (
        .clk       (clk),
        .rst       (rst),
        .listen_en (state == DIR_IN),
        .chk_en    (par_chk_en),
        .clr       (err_clr | xfer_start),
        .pin_data  (bus_data_in),
        .pin_par   (bus_par_in),
        .strobe    (rx_strobe),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .err       (par_err)
    );

    // R4: a capture and a drive never coexist
    assert_no_capture_while_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_data_oe != '0 || bus_par_oe) |-> !rx_valid || $past(state == DIR_IN));

endmodule

// File: tb/scsi_par_dir_unit_tb.sv
module scsi_par_dir_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_out, par_chk_en, err_clr, xfer_start, tx_load, bus_par_in, rx_strobe;
    logic [7:0] tx_byte, bus_data_in;
    logic [7:0] bus_data_oe, bus_data_o, rx_byte;
    logic       bus_par_oe, bus_par_o, rx_valid, par_err, dir_is_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    scsi_par_dir_unit dut_i (
        .clk(clk), .rst(rst), .mode_out(mode_out), .par_chk_en(par_chk_en),
        .err_clr(err_clr), .xfer_start(xfer_start), .tx_byte(tx_byte),
        .tx_load(tx_load), .bus_data_in(bus_data_in), .bus_par_in(bus_par_in),
        .rx_strobe(rx_strobe), .bus_data_oe(bus_data_oe), .bus_data_o(bus_data_o),
        .bus_par_oe(bus_par_oe), .bus_par_o(bus_par_o), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .par_err(par_err), .dir_is_out(dir_is_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int ones(input logic [8:0] v);
        int n = 0;
        for (int i = 0; i < 9; i++) n += int'(v[i]);
        return n;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; mode_out = 0; par_chk_en = 1; err_clr = 0; xfer_start = 0;
        tx_load = 0; tx_byte = 0; bus_data_in = 8'hFF; bus_par_in = 1; rx_strobe = 0;
        tick(); tick();
        chk("R1 dir", 32'(dir_is_out), 0);
        chk("R1 oe", 32'({bus_data_oe, bus_par_oe}), 0);
        chk("R1 err", 32'(par_err), 0);
        rst = 0;
        tick();
        chk("R1 post dir", 32'(dir_is_out), 0);
        chk("R1 post valid", 32'(rx_valid), 0);
        chk("R1 post err", 32'(par_err), 0);

        // R6 R7 R8: sweep all pin patterns, each judged alone
        for (int v = 0; v < 512; v++) begin
            bus_data_in = v[7:0]; bus_par_in = v[8];
            rx_strobe = 1; xfer_start = 1;
            tick();
            chk("R6 byte", 32'(rx_byte), 32'(~v[7:0] & 8'hFF));
            chk("R6 valid", 32'(rx_valid), 1);
            chk("R7 err", 32'(par_err), 32'((ones(~v[8:0]) % 2) == 0));
        end
        rx_strobe = 0; xfer_start = 0;

        // R9: disabled check ignores bad parity
        xfer_start = 1; tick(); xfer_start = 0;
        par_chk_en = 0;
        bus_data_in = 8'hFE; bus_par_in = 1'b0; rx_strobe = 1;   // 2 low pins: even
        tick(); tick();
        chk("R9 no err", 32'(par_err), 0);
        rx_strobe = 0; par_chk_en = 1;

        // R8: sticky across good bytes, then cleared
        rx_strobe = 1; tick();
        chk("R8 set", 32'(par_err), 1);
        bus_data_in = 8'hFE; bus_par_in = 1'b1;                  // 1 low pin: good
        tick(); tick(); tick();
        chk("R8 sticky", 32'(par_err), 1);
        rx_strobe = 0; err_clr = 1; tick(); err_clr = 0;
        chk("R8 clear", 32'(par_err), 0);
        chk("R6 no strobe", 32'(rx_valid), 0);
        // idle bad bus without strobe
        bus_par_in = 1'b0; tick(); tick();
        chk("R6 idle ignored", 32'(par_err), 0);

        // R5: turnaround into output
        tx_byte = 8'hA5; tx_load = 1; mode_out = 1;
        tick(); tx_load = 0;
        chk("R5 turn dir", 32'(dir_is_out), 0);
        chk("R5 turn oe", 32'({bus_data_oe, bus_par_oe}), 0);
        tick();
        chk("R5 out dir", 32'(dir_is_out), 1);
        chk("R2 first", 32'(bus_data_oe), 32'hA5);

        // R2 R3 sweep
        for (int b = 0; b < 256; b++) begin
            tx_byte = b[7:0]; tx_load = 1;
            tick();
            chk("R2 oe", 32'(bus_data_oe), 32'(b));
            chk("R3 par", 32'(bus_par_oe), 32'((ones({1'b0, b[7:0]}) % 2) == 0));
            chk("R2 zero", 32'({bus_data_o, bus_par_o}), 0);
        end
        tx_load = 0;

        // R6: strobes ignored while driving
        bus_data_in = 8'h00; bus_par_in = 1'b0; rx_strobe = 1;
        tick(); tick();
        chk("R6 out valid", 32'(rx_valid), 0);
        chk("R6 out err", 32'(par_err), 0);
        chk("R6 out byte", 32'(rx_byte), 32'h01);
        rx_strobe = 0;

        // R4 R5: leaving output releases at once
        tx_byte = 8'hFF; tx_load = 1; tick(); tx_load = 0;
        mode_out = 0; tick();
        chk("R4 released", 32'({bus_data_oe, bus_par_oe}), 0);
        chk("R5 back dir", 32'(dir_is_out), 0);
        tick();
        bus_data_in = 8'h7F; bus_par_in = 1'b1; rx_strobe = 1;
        tick(); rx_strobe = 0;
        chk("R6 back in", 32'(rx_byte), 32'h80);
        chk("R4 still released", 32'({bus_data_oe, bus_par_oe}), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule